// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a bus-programmed watchdog built on a down-counter. An oscillator-side tick enable is divided by a selectable ratio to make the count tick. Each count tick lowers the counter by one. Software keeps the watchdog alive by writing a two-byte key to the refresh register: first 0x00, then 0xFF. That pair reloads the counter a fixed number of count ticks later. The refresh is only legal while the counter sits inside a window. The two edges of that window are programmed as fractions of the timeout period.

When the counter runs out, or when a refresh arrives outside the window, the block signals an error. The error takes the form of a single-cycle pulse on either the reset-request output or the interrupt output, depending on a selection bit. A sticky flag remembers that an error happened. Writing the control register stops the counter and preloads it. Counting resumes only after the next correct refresh key.

Top module: `wdog_window_timer`

## Requirements
- R1: After reset both outputs are low. The control register reads 0x0000, the reset-control register reads 0x0000, and the counter (offset 4) reads 1023. The counter does not move until a refresh key has been accepted.
- R2: A refresh is a write of 0x00 to offset 0, followed by a write of 0xFF to offset 0. Any other value written to offset 0 between the two breaks the pair. A 0xFF that is not preceded by 0x00 has no effect. The first accepted key after reset, after a control write or after an error loads the reload value and starts counting.
- R3: Control bits [1:0] select the reload value: 0 gives 1023, 1 gives 4095, 2 gives 8191 and 3 gives 16383. The writable control bits are 0x33F3, and all other bits read back as 0.
- R4: Control bits [7:4] select how many oscillator ticks make one count tick: 0 means 1, 1 means 4, 2 means 16, 3 means 32, 4 means 64, 5 means 256, and every other code means 1. The divider restarts when the counter starts. Cycles with the oscillator tick low do not advance the counter.
- R5: While running, the counter falls by one per count tick. A count tick that finds the counter at 0 is an underflow error. After a start with reload R at a divide ratio of 1 with a steady tick, the error pulse follows the start edge by R+1 edges.
- R6: An accepted refresh while running reloads the counter on the fourth count tick after the 0xFF write. Until then the counter keeps falling.
- R7: Let P be the reload value plus 1. Control bits [13:12] set the upper limit at P/4, P/2, 3P/4 or P for codes 0 to 3. Control bits [9:8] set the lower limit at 3P/4, P/2, P/4 or 0 for codes 0 to 3. A running refresh with the counter above the upper limit or below the lower limit is an error. When the upper limit is below the lower limit, every running refresh is an error.
- R8: Reset-control bit 7 clear sends each error to the reset output. Bit 7 set sends each error to the interrupt output. The pulse lasts one cycle and is visible right after the clock edge that detected the error. The two outputs are never high together.
- R9: After an error the counter stops at the reload value until a new key is accepted. Reset-control bit 0 reads 1 from the first error on and is cleared only by bus reset.
- R10: A control write while running stops the counter and loads the new reload value. No error follows from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous bus reset |
| osc_tick_i | input | 1 | Oscillator tick enable, already synchronised |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 3 | Byte offset: 0 refresh, 2 control, 4 counter (read), 6 reset-control |
| bus_wdata_i | input | 16 | Write data; byte registers use bits [7:0] |
| bus_rdata_o | output | 16 | Combinational read data for bus_addr_i |
| wdt_rst_o | output | 1 | One-cycle reset request pulse |
| wdt_irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The counter is run to underflow from a fresh start at ratio 1, and again at ratio 4 with a stretch of oscillator ticks held low. These runs tell the reload value and the divider apart from the tick gating. Refresh keys are tried in four positions: early in the period, late in the period, inside a legal window, and under a setting with no legal window. This separates the upper-limit test from the lower-limit test. Malformed keys (a lone 0xFF, and a foreign byte between the two halves) must leave the count untouched. The same error is routed to both outputs in turn, which checks the response selection.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [2:0]  OFS_REFRESH = 3'd0;
    localparam logic [2:0]  OFS_CTRL    = 3'd2;
    localparam logic [2:0]  OFS_COUNT   = 3'd4;
    localparam logic [2:0]  OFS_RSTCTL  = 3'd6;
    localparam logic [15:0] CTRL_MASK   = 16'h33F3;
    localparam logic [7:0]  KEY_FIRST   = 8'h00;
    localparam logic [7:0]  KEY_SECOND  = 8'hFF;

    // left shift of the base period for each timeout code
    function automatic int period_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 4;
        endcase
    endfunction

    // oscillator ticks per count tick
    function automatic int div_ratio(input logic [3:0] code);
        case (code)
            4'd1:    return 4;
            4'd2:    return 16;
            4'd3:    return 32;
            4'd4:    return 64;
            4'd5:    return 256;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick_i,
    input  logic       restart_i,
    input  logic [3:0] div_sel_i,
    output logic       cnt_tick_o
);

    logic [PRE_W-1:0] pre_q, pre_d, term;

    always_comb begin
        term       = PRE_W'(wdog_pkg::div_ratio(div_sel_i) - 1);
        cnt_tick_o = osc_tick_i && (pre_q >= term);
        pre_d      = pre_q;
        if (restart_i)
            pre_d = '0;
        else if (osc_tick_i)
            pre_d = cnt_tick_o ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= term);  // R4

endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
    parameter int CNT_W = 14
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [1:0]       upper_sel_i,
    input  logic [1:0]       lower_sel_i,
    output logic             outside_o
);

    localparam int LW = CNT_W + 2;

    logic [LW-1:0] quarter, upper_lim, lower_lim, cnt_x;

    always_comb begin
        quarter = (LW'(reload_i) + LW'(1)) >> 2;
        cnt_x   = LW'(cnt_i);
        case (upper_sel_i)
            2'd0:    upper_lim = quarter;
            2'd1:    upper_lim = quarter << 1;
            2'd2:    upper_lim = (quarter << 1) + quarter;
            default: upper_lim = quarter << 2;
        endcase
        case (lower_sel_i)
            2'd0:    lower_lim = (quarter << 1) + quarter;
            2'd1:    lower_lim = quarter << 1;
            2'd2:    lower_lim = quarter;
            default: lower_lim = '0;
        endcase
        outside_o = (cnt_x > upper_lim) || (cnt_x < lower_lim);
    end

endmodule

// File: rtl/wdog_window_timer.sv
module wdog_window_timer #(
    parameter int CNT_W      = 14,
    parameter int BASE_LOG2  = 10,
    parameter int PRE_W      = 8,
    parameter int RELOAD_LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick_i,
    input  logic        bus_we_i,
    input  logic [2:0]  bus_addr_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic        wdt_rst_o,
    output logic        wdt_irq_o
);
    import wdog_pkg::*;

    localparam int LAT_W = $clog2(RELOAD_LAT + 1);

    typedef struct packed {
        logic [15:0]      ctrl;
        logic             irq_sel;
        logic             sticky;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             key_half;
        logic [LAT_W-1:0] pend;
        logic             rst_p;
        logic             irq_p;
    } state_t;

    state_t st_q, st_d;

    logic wr_ref, wr_ctl, wr_rsc, key_ok, start_evt, win_bad, cnt_tick, err;
    logic [CNT_W-1:0] reload_cur, reload_new;

    function automatic logic [CNT_W-1:0] reload_for(input logic [1:0] code);
        return CNT_W'((1 << (BASE_LOG2 + period_shift(code))) - 1);
    endfunction

    assign wr_ref     = bus_we_i && (bus_addr_i == OFS_REFRESH);
    assign wr_ctl     = bus_we_i && (bus_addr_i == OFS_CTRL);
    assign wr_rsc     = bus_we_i && (bus_addr_i == OFS_RSTCTL);
    assign key_ok     = wr_ref && st_q.key_half && (bus_wdata_i[7:0] == KEY_SECOND);
    assign start_evt  = key_ok && !st_q.run;
    assign reload_cur = reload_for(st_q.ctrl[1:0]);
    assign reload_new = reload_for(bus_wdata_i[1:0]);

    wdog_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick_i (osc_tick_i),
        .restart_i  (wr_ctl || start_evt),
        .div_sel_i  (st_q.ctrl[7:4]),
        .cnt_tick_o (cnt_tick)
    );

    wdog_window #(.CNT_W(CNT_W)) u_win (
        .cnt_i       (st_q.cnt),
        .reload_i    (reload_cur),
        .upper_sel_i (st_q.ctrl[13:12]),
        .lower_sel_i (st_q.ctrl[9:8]),
        .outside_o   (win_bad)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rst_p = 1'b0;
        st_d.irq_p = 1'b0;
        err        = 1'b0;
        if (wr_rsc) st_d.irq_sel  = bus_wdata_i[7];
        if (wr_ref) st_d.key_half = (bus_wdata_i[7:0] == KEY_FIRST);
        if (wr_ctl) begin
            st_d.ctrl = bus_wdata_i & CTRL_MASK;
            st_d.run  = 1'b0;
            st_d.cnt  = reload_new;
            st_d.pend = '0;
        end else if (start_evt) begin
            st_d.run  = 1'b1;
            st_d.cnt  = reload_cur;
            st_d.pend = '0;
        end else if (st_q.run) begin
            if (cnt_tick) begin
                if (st_q.cnt == '0) begin
                    err = 1'b1;
                end else if (st_q.pend == LAT_W'(1)) begin
                    st_d.cnt  = reload_cur;
                    st_d.pend = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.pend != '0) st_d.pend = st_q.pend - 1'b1;
                end
            end
            if (key_ok) begin
                if (win_bad) err = 1'b1;
                else         st_d.pend = LAT_W'(RELOAD_LAT);
            end
        end
        if (err) begin
            st_d.run    = 1'b0;
            st_d.cnt    = reload_cur;
            st_d.pend   = '0;
            st_d.sticky = 1'b1;
            st_d.rst_p  = !st_q.irq_sel;
            st_d.irq_p  = st_q.irq_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= reload_for(2'b00);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            OFS_CTRL:   bus_rdata_o = st_q.ctrl;
            OFS_COUNT:  bus_rdata_o = 16'(st_q.cnt);
            OFS_RSTCTL: bus_rdata_o = {8'h00, st_q.irq_sel, 6'b000000, st_q.sticky};
            default:    bus_rdata_o = 16'h0000;
        endcase
    end

    assign wdt_rst_o = st_q.rst_p;
    assign wdt_irq_o = st_q.irq_p;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !bus_we_i) |=> $stable(st_q.cnt));  // R1
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !cnt_tick && !bus_we_i) |=> $stable(st_q.cnt));  // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && cnt_tick && !bus_we_i && st_q.cnt != '0 && st_q.pend != LAT_W'(1))
        |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1));  // R5
    AST_UNDERFLOW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && cnt_tick && !bus_we_i && st_q.cnt == '0) |=> (wdt_rst_o || wdt_irq_o));  // R5
    AST_WINDOW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (key_ok && st_q.run && win_bad) |=> (wdt_rst_o || wdt_irq_o));  // R7
    AST_ONE_CYCLE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);  // R8
    AST_ONE_CYCLE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq_o |=> !wdt_irq_o);  // R8
    AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst_o && wdt_irq_o));  // R8
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst_o || wdt_irq_o) |-> st_q.sticky);  // R9
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sticky |=> st_q.sticky);  // R9
    AST_CTL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (!st_q.run && !wdt_rst_o && !wdt_irq_o));  // R10

endmodule

// File: tb/wdog_window_timer_test.sv
module wdog_window_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick_i = 1'b1;
    logic        bus_we_i = 1'b0;
    logic [2:0]  bus_addr_i = 3'd0;
    logic [15:0] bus_wdata_i = 16'h0000;
    logic [15:0] bus_rdata_o;
    logic        wdt_rst_o, wdt_irq_o;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;
    int exp_kind_q[$];
    int exp_edge_q[$];

    localparam int K_RST = 1;
    localparam int K_IRQ = 2;

    always #4 clk = ~clk;

    wdog_window_timer uut (
        .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    // monitor: pops expected pulses as the design raises them
    always @(posedge clk) begin
        #1;
        if (wdt_rst_o || wdt_irq_o) begin
            if (exp_kind_q.size() == 0) begin
                chk("R8 unexpected pulse at edge", edge_cnt, -1);
            end else begin
                int k, e;
                k = exp_kind_q.pop_front();
                e = exp_edge_q.pop_front();
                chk("R8 pulse kind", wdt_irq_o ? K_IRQ : K_RST, k);
                chk("R5 R7 pulse edge", edge_cnt, e);
            end
        end
    end

    task automatic expect_pulse(input int kind, input int at_edge);
        exp_kind_q.push_back(kind);
        exp_edge_q.push_back(at_edge);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input int kind);
        @(negedge clk);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        if (kind != 0) expect_pulse(kind, edge_cnt + 1);
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic refresh(input int kind);
        wr(3'd0, 16'h0000, 0);
        wr(3'd0, 16'h00FF, kind);
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_addr_i = a;
        #1;
        v = int'(bus_rdata_o);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int e);
        while (edge_cnt < e) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, s, f, c1;
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(1);

        // R1 reset state
        chk("R1 rst_o", int'(wdt_rst_o), 0);
        chk("R1 irq_o", int'(wdt_irq_o), 0);
        rd(3'd2, v); chk("R1 ctrl", v, 0);
        rd(3'd6, v); chk("R1 rstctl", v, 0);
        rd(3'd4, v); chk("R1 count", v, 1023);
        wait_edges(200);
        rd(3'd4, v); chk("R1 idle count", v, 1023);

        // R3 timeout codes and mask
        wr(3'd2, 16'h3303, 0); rd(3'd4, v); chk("R3 code3", v, 16383);
        wr(3'd2, 16'h3302, 0); rd(3'd4, v); chk("R3 code2", v, 8191);
        wr(3'd2, 16'h3301, 0); rd(3'd4, v); chk("R3 code1", v, 4095);
        wr(3'd2, 16'hFFFF, 0); rd(3'd2, v); chk("R3 mask", v, 16'h33F3);
        wr(3'd2, 16'h3300, 0); rd(3'd4, v); chk("R3 code0", v, 1023);

        // R5 plain underflow from start
        refresh(0); s = edge_cnt;
        expect_pulse(K_RST, s + 1024);
        wait_edges(10);
        rd(3'd4, v); chk("R5 counting", v, 1013);
        wait_until(s + 1030);
        rd(3'd6, v); chk("R9 sticky", v, 1);
        rd(3'd4, v); chk("R9 parked", v, 1023);
        wait_edges(50);
        rd(3'd4, v); chk("R9 still parked", v, 1023);

        // R10 control write stops the counter
        refresh(0); s = edge_cnt;
        wait_edges(20);
        wr(3'd2, 16'h3300, 0);
        rd(3'd4, v); chk("R10 reloaded", v, 1023);
        wait_edges(1100);
        rd(3'd4, v); chk("R10 held", v, 1023);

        // R6 reload latency
        refresh(0); s = edge_cnt;
        wait_edges(100);
        refresh(0); f = edge_cnt;
        rd(3'd4, c1); chk("R6 still falling", c1, 1023 - (f - s));
        wait_edges(3);
        rd(3'd4, v); chk("R6 before reload", v, c1 - 3);
        wait_edges(1);
        rd(3'd4, v); chk("R6 reload", v, 1023);
        expect_pulse(K_RST, f + 1028);
        wait_until(f + 1032);

        // R2 malformed keys
        refresh(0); s = edge_cnt;
        wr(3'd0, 16'h00FF, 0);
        wr(3'd0, 16'h0055, 0);
        wr(3'd0, 16'h00FF, 0);
        wr(3'd0, 16'h0000, 0);
        wr(3'd0, 16'h0011, 0);
        wr(3'd0, 16'h00FF, 0);
        wait_edges(6);
        rd(3'd4, v); chk("R2 no reload", v, 1023 - (edge_cnt - s));
        expect_pulse(K_RST, s + 1024);
        wait_until(s + 1030);

        // R7 window 50% .. 25%
        wr(3'd2, 16'h1200, 0);
        refresh(0);
        refresh(K_RST);                       // R7 too early
        wait_edges(4);
        refresh(0); s = edge_cnt;
        wait_edges(800);
        refresh(K_RST);                       // R7 too late
        wait_edges(4);
        wr(3'd6, 16'h0080, 0);
        refresh(0); s = edge_cnt;
        wait_edges(600);
        refresh(0); f = edge_cnt;             // R7 inside window
        wait_edges(4);
        rd(3'd4, v); chk("R7 legal refresh reloads", v, 1023);
        expect_pulse(K_IRQ, f + 1028);        // R8 interrupt route
        wait_until(f + 1032);
        rd(3'd6, v); chk("R8 R9 rstctl", v, 16'h0081);

        // R7 no legal window
        wr(3'd2, 16'h0000, 0);
        refresh(0);
        wait_edges(500);
        refresh(K_IRQ);
        wait_edges(4);

        // R4 divide by 4 with oscillator gaps
        wr(3'd6, 16'h0000, 0);
        wr(3'd2, 16'h3310, 0);
        refresh(0); s = edge_cnt;
        wait_edges(9);
        rd(3'd4, v); chk("R4 div4 count", v, 1021);
        osc_tick_i = 1'b0;
        wait_edges(40);
        rd(3'd4, v); chk("R4 gated", v, 1021);
        osc_tick_i = 1'b1;
        expect_pulse(K_RST, s + 4136);
        wait_until(s + 4140);

        // R9 sticky cleared by reset only
        rd(3'd6, v); chk("R9 sticky before reset", v, 1);
        rst_n = 1'b0;
        wait_edges(2);
        rst_n = 1'b1;
        wait_edges(1);
        rd(3'd6, v); chk("R9 cleared by reset", v, 0);
        rd(3'd2, v); chk("R1 ctrl after reset", v, 0);

        chk("R5 all expected pulses seen", exp_kind_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule